// File: doc/BRIEF.md
# Range TLB Invalidation Controller

This block sits beside the address-translation caches of a memory management unit and removes stale entries from them on software command. Software writes a target mask that selects one or both translation caches, a first-page address and a last-page address, and then writes a command word. One command code drops every entry in the selected caches in a single cycle. Another code walks the inclusive page range one 4 KiB page at a time and raises an invalidate request for each page, held until the cache side acknowledges it.

When a range walk finishes, a sticky completion flag is set. Software polls it and clears it by writing zero. Software that waits too long for the flag falls back to a full invalidation. For that reason the full command is accepted in every state, and it abandons any walk in progress. The cache arrays are not part of the block. They are reached through the request/acknowledge port and a one-cycle flush strobe.

Top module: `tlbinv_top`

## Requirements
- R1: After reset, no invalidate request and no flush strobe are driven, and every register reads as zero.
- R2: Registers sit at word offsets 0 (target mask, bits [1:0]), 1 (first address), 2 (last address), 3 (command) and 4 (completion flag). The address registers keep only bits [31:12] and read back with bits [11:0] zero. The command register reads as zero.
- R3: A command write of 1 starts a range walk and a write of 2 starts a full invalidation. Any other command value has no effect.
- R4: Starting in the cycle after a range command, the block holds inv_req high and presents each page number from the first page up to and including the last page, in ascending order. inv_tgt carries the target mask that was latched when the command was taken.
- R5: While inv_ack is low, the request and its page number stay unchanged. The walk advances one page on each cycle in which inv_ack is high.
- R6: The completion flag (offset 4, reads 1 when set) is set in the cycle after the last page is acknowledged. It stays set until software writes 0 to offset 4, and a nonzero write there is ignored. A completion that lands in the same cycle as a clearing write wins. Accepting a non-empty range command clears the flag.
- R7: A range command whose last page is below its first page, or whose target mask is zero, drives no request and sets the completion flag in the next cycle.
- R8: A full command pulses flush_o high for exactly the one cycle after the write. flush_tgt equals the target mask during that cycle. The completion flag is not changed.
- R9: A full command during a range walk is accepted. Requests stop in the next cycle and the abandoned walk never sets the completion flag.
- R10: A range command during a walk is ignored, and register writes during a walk do not change the pages or targets of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word offset |
| rd_data | output | 32 | Register read data (combinational) |
| inv_req | output | 1 | Per-page invalidate request |
| inv_page | output | 20 | Page number being invalidated |
| inv_tgt | output | 2 | Caches targeted by the current request |
| inv_ack | input | 1 | Cache side accepts the current page |
| flush_o | output | 1 | One-cycle full-invalidate strobe |
| flush_tgt | output | 2 | Caches targeted by the full invalidate |

## Verification
The hardest situations to reach are the ones that depend on exact cycle alignment between the walk and software. One is a clearing write to the completion flag that lands on the very edge where the last page is acknowledged. The other is a full command that arrives mid-walk while the acknowledge is high. The stimulus counts the walk length from the known page bounds and places the write on that edge. Randomized acknowledge patterns then stretch walks so that abort, ignored range commands and register rewrites occur with a request outstanding. A behavioural model follows every cycle and checks each output.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int REG_AW = 3;

  // register word offsets
  localparam logic [REG_AW-1:0] OFS_MASK  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_FIRST = 3'd1;
  localparam logic [REG_AW-1:0] OFS_LAST  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMD   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_DONE  = 3'd4;

  // command codes
  localparam int CMD_RANGE = 1;
  localparam int CMD_FULL  = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RANGE = 2'd1,
    OP_FULL  = 2'd2
  } op_e;
endpackage

// File: rtl/tlbinv_regs.sv
module tlbinv_regs
  import tlbinv_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NCACHE     = 2,
  localparam int PAGE_W    = DATA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               done_set,
  input  logic               done_clr,
  output op_e                op_go,
  output logic [NCACHE-1:0]  mask_q,
  output logic [PAGE_W-1:0]  first_q,
  output logic [PAGE_W-1:0]  last_q,
  output logic               done_q
);

  function automatic logic [PAGE_W-1:0] page_of(input logic [DATA_W-1:0] v);
    return v[DATA_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic [DATA_W-1:0] addr_of(input logic [PAGE_W-1:0] p);
    return {p, {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic op_e decode_op(input logic [DATA_W-1:0] v);
    if (v == DATA_W'(CMD_RANGE)) return OP_RANGE;
    if (v == DATA_W'(CMD_FULL))  return OP_FULL;
    return OP_NONE;
  endfunction

  logic wr_cmd, wr_done_zero;
  assign wr_cmd       = wr_en && (wr_addr == OFS_CMD);
  assign wr_done_zero = wr_en && (wr_addr == OFS_DONE) && (wr_data == '0);
  assign op_go        = wr_cmd ? decode_op(wr_data) : OP_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == OFS_MASK)  mask_q  <= wr_data[NCACHE-1:0];
      if (wr_addr == OFS_FIRST) first_q <= page_of(wr_data);
      if (wr_addr == OFS_LAST)  last_q  <= page_of(wr_data);
    end
  end

  // set has priority over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        done_q <= 1'b0;
    else if (done_set)                 done_q <= 1'b1;
    else if (done_clr || wr_done_zero) done_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      OFS_MASK:  rd_data = DATA_W'(mask_q);
      OFS_FIRST: rd_data = addr_of(first_q);
      OFS_LAST:  rd_data = addr_of(last_q);
      OFS_DONE:  rd_data = DATA_W'(done_q);
      default:   rd_data = '0;
    endcase
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_q);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !wr_done_zero && !done_clr |=> done_q);
  a_r6_only_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !done_set |=> !done_q);

endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker
  import tlbinv_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int NCACHE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_go,
  input  logic [NCACHE-1:0] mask,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] last_pg,
  input  logic              inv_ack,
  output logic              inv_req,
  output logic [PAGE_W-1:0] inv_page,
  output logic [NCACHE-1:0] inv_tgt,
  output logic              done_set,
  output logic              done_clr
);

  logic              busy_q;
  logic [PAGE_W-1:0] cur_q, end_q;
  logic [NCACHE-1:0] msk_q;

  // named events for the assertions
  logic range_take, empty, abort, step, at_end;
  assign abort      = (op_go == OP_FULL);
  assign range_take = (op_go == OP_RANGE) && !busy_q;
  assign empty      = (last_pg < first_pg) || (mask == '0);
  assign step       = busy_q && inv_ack && !abort;
  assign at_end     = (cur_q == end_q);
  assign done_set   = (step && at_end) || (range_take && empty);
  assign done_clr   = range_take && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
      msk_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (inv_ack) begin
        if (at_end) busy_q <= 1'b0;
        else        cur_q  <= cur_q + PAGE_W'(1);
      end
    end else if (range_take && !empty) begin
      busy_q <= 1'b1;
      cur_q  <= first_pg;
      end_q  <= last_pg;
      msk_q  <= mask;
    end
  end

  assign inv_req  = busy_q;
  assign inv_page = cur_q;

  for (genvar g = 0; g < NCACHE; g++) begin : g_tgt
    assign inv_tgt[g] = busy_q && msk_q[g];
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !inv_ack && !abort |=> inv_req && $stable(inv_page) && $stable(inv_tgt));
  a_r4_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    step && !at_end |=> inv_req && (inv_page == $past(inv_page) + PAGE_W'(1)));
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> (inv_page <= end_q) && (inv_tgt != '0));
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !inv_req);
  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    range_take && empty |=> !inv_req);
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && !inv_ack && (op_go == OP_RANGE) |=> $stable(inv_page));

endmodule

// File: rtl/tlbinv_flush.sv
module tlbinv_flush
  import tlbinv_pkg::*;
#(
  parameter int NCACHE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_go,
  input  logic [NCACHE-1:0] mask,
  output logic              flush_o,
  output logic [NCACHE-1:0] flush_tgt
);

  logic fire;
  assign fire = (op_go == OP_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o   <= 1'b0;
      flush_tgt <= '0;
    end else begin
      flush_o   <= fire;
      flush_tgt <= fire ? mask : '0;
    end
  end

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flush_o && (flush_tgt == $past(mask)));
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !flush_o && (flush_tgt == '0));

endmodule

// File: rtl/tlbinv_top.sv
module tlbinv_top
  import tlbinv_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NCACHE     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [REG_AW-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [REG_AW-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         inv_req,
  output logic [DATA_W-PAGE_SHIFT-1:0] inv_page,
  output logic [NCACHE-1:0]            inv_tgt,
  input  logic                         inv_ack,
  output logic                         flush_o,
  output logic [NCACHE-1:0]            flush_tgt
);

  localparam int PAGE_W = DATA_W - PAGE_SHIFT;

  op_e               op_go;
  logic [NCACHE-1:0] mask_q;
  logic [PAGE_W-1:0] first_q, last_q;
  logic              done_q, done_set, done_clr;

  tlbinv_regs #(
    .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT), .NCACHE(NCACHE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .done_set(done_set), .done_clr(done_clr),
    .op_go(op_go), .mask_q(mask_q), .first_q(first_q), .last_q(last_q),
    .done_q(done_q)
  );

  tlbinv_walker #(.PAGE_W(PAGE_W), .NCACHE(NCACHE)) u_walk (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .mask(mask_q),
    .first_pg(first_q), .last_pg(last_q), .inv_ack(inv_ack),
    .inv_req(inv_req), .inv_page(inv_page), .inv_tgt(inv_tgt),
    .done_set(done_set), .done_clr(done_clr)
  );

  tlbinv_flush #(.NCACHE(NCACHE)) u_flush (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .mask(mask_q),
    .flush_o(flush_o), .flush_tgt(flush_tgt)
  );

  a_r9_no_done_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go == OP_FULL) && !done_q |=> !done_q);

endmodule

// File: tb/tlbinv_top_tb.sv
module tlbinv_top_tb;
  localparam int PW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        inv_req;
  logic [PW-1:0] inv_page;
  logic [1:0]  inv_tgt;
  logic        inv_ack = 1'b1;
  logic        flush_o;
  logic [1:0]  flush_tgt;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlbinv_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .inv_req(inv_req), .inv_page(inv_page), .inv_tgt(inv_tgt),
    .inv_ack(inv_ack), .flush_o(flush_o), .flush_tgt(flush_tgt)
  );

  // behavioural reference state
  bit          m_busy, m_flush, m_done;
  logic [PW-1:0] m_cur, m_end, m_lo, m_hi;
  logic [1:0]  m_msk, m_sel, m_fmsk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_sel};
      3'd1: return {m_lo, 12'd0};
      3'd2: return {m_hi, 12'd0};
      3'd4: return m_done ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_flush = 0; m_done = 0; m_cur = '0; m_end = '0;
      m_lo = '0; m_hi = '0; m_msk = '0; m_sel = '0; m_fmsk = '0;
    end else begin
      bit go_r, go_f, set_d, clr_d;
      go_r = wr_en && wr_addr == 3'd3 && wr_data == 32'd1;
      go_f = wr_en && wr_addr == 3'd3 && wr_data == 32'd2;
      set_d = 0; clr_d = 0;
      m_flush = go_f;
      m_fmsk  = go_f ? m_sel : 2'b00;
      if (go_f) m_busy = 0;
      else if (m_busy) begin
        if (inv_ack) begin
          if (m_cur == m_end) begin m_busy = 0; set_d = 1; end
          else m_cur = m_cur + 1;
        end
      end else if (go_r) begin
        if (m_hi < m_lo || m_sel == 2'b00) set_d = 1;
        else begin m_busy = 1; m_cur = m_lo; m_end = m_hi; m_msk = m_sel; clr_d = 1; end
      end
      if (set_d) m_done = 1;
      else if (clr_d || (wr_en && wr_addr == 3'd4 && wr_data == 0)) m_done = 0;
      if (wr_en && wr_addr == 3'd0) m_sel = wr_data[1:0];
      if (wr_en && wr_addr == 3'd1) m_lo = wr_data[31:12];
      if (wr_en && wr_addr == 3'd2) m_hi = wr_data[31:12];
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) if (!finished) begin
    chk(inv_req === m_busy, "R4 request", inv_req, m_busy);
    if (m_busy) begin
      chk(inv_page === m_cur, "R4 page", inv_page, m_cur);
      chk(inv_tgt === m_msk, "R4 targets", inv_tgt, m_msk);
    end else chk(inv_tgt === 2'b00, "R4 idle targets", inv_tgt, 0);
    chk(flush_o === m_flush, "R8 flush strobe", flush_o, m_flush);
    chk(flush_tgt === m_fmsk, "R8 flush targets", flush_tgt, m_fmsk);
    chk(rd_data === mread(rd_addr), "R2 readback", rd_data, mread(rd_addr));
  end

  // drivers: called at posedge+1
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a; #2;
    chk(rd_data === exp, tag, rd_data, exp);
    rd_addr = 3'd4;
  endtask

  task automatic rand_ack(input int n);
    repeat (n) begin inv_ack = 1'($urandom_range(0, 1)); @(posedge clk); #1; end
    inv_ack = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rd_addr = 3'd4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(!inv_req && !flush_o, "R1 outputs idle", {inv_req, flush_o}, 0);
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'd0, "R1 register zero");

    // R2 storage and masking
    wr(3'd1, 32'h1234_5ABC);
    rd_chk(3'd1, 32'h1234_5000, "R2 first masked");
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'd3, "R2 mask bits");
    rd_chk(3'd3, 32'd0, "R2 command reads zero");

    // R4 basic walk, pages 0x10..0x12, both caches
    wr(3'd0, 32'd3); wr(3'd1, 32'h0001_0000); wr(3'd2, 32'h0001_2FFF);
    wr(3'd3, 32'd1);
    chk(inv_req && inv_page == 20'h10, "R4 first page", inv_page, 20'h10);
    idle(4);
    rd_chk(3'd4, 32'd1, "R6 done after walk");
    wr(3'd4, 32'd5);
    rd_chk(3'd4, 32'd1, "R6 nonzero write ignored");
    wr(3'd4, 32'd0);
    rd_chk(3'd4, 32'd0, "R6 zero write clears");

    // R4 single page boundary, cache 1 only
    wr(3'd0, 32'd2); wr(3'd1, 32'h0ABC_D000); wr(3'd2, 32'h0ABC_DFFF);
    wr(3'd3, 32'd1);
    chk(inv_tgt == 2'b10, "R4 single page target", inv_tgt, 2'b10);
    idle(2);
    rd_chk(3'd4, 32'd1, "R4 single page done");

    // R6 accepting a range clears done; R5 random backpressure
    wr(3'd0, 32'd1); wr(3'd1, 32'h0000_0000); wr(3'd2, 32'h0000_7000);
    wr(3'd3, 32'd1);
    rd_chk(3'd4, 32'd0, "R6 start clears done");
    rand_ack(40);
    idle(10);
    rd_chk(3'd4, 32'd1, "R5 done after stalled walk");

    // R7 empty ranges
    wr(3'd4, 32'd0);
    wr(3'd1, 32'h0000_5000); wr(3'd2, 32'h0000_4000);
    wr(3'd3, 32'd1);
    chk(!inv_req, "R7 reversed range no request", inv_req, 0);
    rd_chk(3'd4, 32'd1, "R7 reversed range done");
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd0); wr(3'd2, 32'h0000_9000);
    wr(3'd3, 32'd1);
    chk(!inv_req, "R7 zero mask no request", inv_req, 0);
    rd_chk(3'd4, 32'd1, "R7 zero mask done");

    // R8 full invalidate leaves done alone
    wr(3'd0, 32'd2);
    wr(3'd3, 32'd2);
    chk(flush_o && flush_tgt == 2'b10, "R8 flush pulse", {flush_o, flush_tgt}, 3'b110);
    idle(1);
    chk(!flush_o, "R8 single cycle", flush_o, 0);
    rd_chk(3'd4, 32'd1, "R8 done unchanged");

    // R3 other command values ignored
    wr(3'd4, 32'd0); wr(3'd0, 32'd3);
    wr(3'd3, 32'd0); wr(3'd3, 32'd3); wr(3'd3, 32'd7);
    chk(!inv_req && !flush_o, "R3 no action", {inv_req, flush_o}, 0);
    rd_chk(3'd4, 32'd0, "R3 done unchanged");

    // R9 full command aborts walk
    wr(3'd1, 32'h0010_0000); wr(3'd2, 32'h0010_9000);
    wr(3'd3, 32'd1);
    idle(3);
    wr(3'd3, 32'd2);
    chk(!inv_req && flush_o, "R9 abort stops requests", {inv_req, flush_o}, 1);
    idle(12);
    rd_chk(3'd4, 32'd0, "R9 aborted walk no done");

    // R10 range command and register writes during walk
    wr(3'd0, 32'd1); wr(3'd1, 32'h0020_0000); wr(3'd2, 32'h0020_5000);
    inv_ack = 0;
    wr(3'd3, 32'd1);
    wr(3'd3, 32'd1);
    wr(3'd0, 32'd2); wr(3'd1, 32'h0030_0000); wr(3'd2, 32'h0020_1000);
    chk(inv_page == 20'h200 && inv_tgt == 2'b01, "R10 walk unchanged", {inv_page, inv_tgt}, {20'h200, 2'b01});
    rand_ack(30);
    idle(8);
    rd_chk(3'd4, 32'd1, "R10 walk completes");

    // R6 completion and clearing write on the same edge
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd3); wr(3'd1, 32'h0004_0000); wr(3'd2, 32'h0004_2000);
    wr(3'd3, 32'd1);
    idle(2);
    wr(3'd4, 32'd0);
    rd_chk(3'd4, 32'd1, "R6 set wins over clear");

    idle(3);
    finish_run();
  end
endmodule